// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with Broadcast Command Decoding

This block is the receive side of a slave on a two-wire, open-drain serial bus (I2C). It watches the clock and data lines, recognises START and STOP conditions, and shifts in the first byte after each START as a 7-bit address plus a direction bit. When that byte names this device for a write, the block acknowledges it and every data byte after it. Each accepted byte is presented once on a data output with a one-cycle strobe.

The block also decodes the reserved address groups. The broadcast (general call) address is acknowledged only while it is enabled. The command byte that follows it can do one of three things. It can reset the device and reload the programmable low bits of the device address from input pins. It can reload those bits without a reset. It can announce a hardware master, whose 7-bit address is captured and whose following bytes are accepted as data. The START byte, reads, and all other reserved addresses are never acknowledged. An address that does not match parks the block until the next START.

Top module: `twi_gc_slave`

## Requirements
- R1: The first byte after any START is taken as address bits [7:1] and a direction bit [0] (0 = write, 1 = read). The block acknowledges the byte only for a write to its own address, which is {BASE_ADDR[6:PROG_W], prog}, where prog holds the programmable bits and resets to BASE_ADDR[PROG_W-1:0]. A read of its own address is not acknowledged.
- R2: A START or repeated START, even one in the middle of a byte or a transfer, clears the bit count and returns the block to address reception.
- R3: An acknowledge pulls SDA low from the falling clock edge that ends the eighth bit until the falling edge that ends the ninth bit. A refusal leaves SDA released. SDA is not driven at any other time.
- R4: The broadcast byte 00h (address 0000000, write) is acknowledged only when gc_en_i is 1. When gc_en_i is 0 it is refused and the block ignores the bus until the next START.
- R5: The command byte 06h after an acknowledged broadcast is acknowledged. It raises soft_rst_o and addr_load_o for the same single cycle, copies addr_pins_i into prog, and clears hw_master_o to 0.
- R6: The command byte 04h after an acknowledged broadcast is acknowledged. It raises addr_load_o alone and copies addr_pins_i into prog. prog changes at no other time.
- R7: A command byte with bit 0 equal to 0, other than 04h and 06h (00h included), is not acknowledged and produces no output pulse.
- R8: A command byte with bit 0 equal to 1 is acknowledged. Its bits [7:1] appear on hw_master_o together with a one-cycle hw_call_o, and the bytes that follow are accepted as data.
- R9: The START byte 01h (address 0000000, read) is never acknowledged.
- R10: Addresses 0000xxx and 1111xxx, other than the broadcast write, are not acknowledged.
- R11: Each data byte in an accepted transfer is acknowledged and appears on rx_data_o, MSB first on the wire, with rx_valid_o high for one cycle.
- R12: A START followed directly by a STOP leaves every output pulse low and does not prevent the next transfer from working.
- R13: After a refused address, the bytes that follow are neither acknowledged nor reported until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| gc_en_i | input | 1 | Enables acknowledging the broadcast address |
| addr_pins_i | input | PROG_W | Programmable address bits, latched on a reload command |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| rx_data_o | output | 8 | Last accepted data byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| soft_rst_o | output | 1 | One-cycle soft reset request |
| addr_load_o | output | 1 | One-cycle pulse when the programmable address bits are reloaded |
| hw_call_o | output | 1 | One-cycle pulse when a hardware master announces itself |
| hw_master_o | output | 7 | Captured hardware master address |

## Verification
The in-RTL properties check the invariants that hold on every cycle. The data line is driven only inside the acknowledge slot. Any START sends the block back to address reception. A soft reset always comes with an address load. The programmable bits change only with a load pulse. Data strobes appear only while a transfer is accepted. Which bytes get acknowledged, and what values they produce, can only be shown by the bench's bus scenarios. Those scenarios cover the reserved addresses, each broadcast command code, a refused address followed by data, a START-STOP pair, and a repeated START that cuts into a byte.

// File: rtl/twi_gc_pkg.sv
package twi_gc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GCMD,
        ST_DATA,
        ST_SKIP
    } twi_state_e;

    localparam logic [7:0] CMD_RESET_LOAD = 8'h06;
    localparam logic [7:0] CMD_LOAD_ONLY  = 8'h04;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_sh_q, scl_sh_d;
    logic [LAST:0] sda_sh_q, sda_sh_d;
    logic          scl_prev_q, sda_prev_q;

    always_comb begin
        scl_sh_d = {scl_sh_q[LAST-1:0], scl_i};
        sda_sh_d = {sda_sh_q[LAST-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= scl_sh_d;
            sda_sh_q   <= sda_sh_d;
            scl_prev_q <= scl_sh_q[LAST];
            sda_prev_q <= sda_sh_q[LAST];
        end
    end

    assign sda_lvl   = sda_sh_q[LAST];
    assign scl_rise  = scl_sh_q[LAST] & ~scl_prev_q;
    assign scl_fall  = ~scl_sh_q[LAST] & scl_prev_q;
    assign start_det = scl_sh_q[LAST] & scl_prev_q & sda_prev_q & ~sda_sh_q[LAST];
    assign stop_det  = scl_sh_q[LAST] & scl_prev_q & ~sda_prev_q & sda_sh_q[LAST];
endmodule

// File: rtl/twi_addr_class.sv
module twi_addr_class (
    input  logic [7:0] byte_i,
    input  logic [6:0] own_addr_i,
    input  logic       gc_en_i,
    output logic       own_hit_o,
    output logic       gc_hit_o,
    output logic       cmd_hw_o,
    output logic       cmd_rst_o,
    output logic       cmd_load_o
);
    import twi_gc_pkg::*;

    logic [6:0] addr7;
    logic       rd;
    logic       rsvd;

    always_comb begin
        addr7      = byte_i[7:1];
        rd         = byte_i[0];
        rsvd       = (addr7[6:3] == 4'b0000) || (addr7[6:3] == 4'b1111);
        gc_hit_o   = (addr7 == 7'd0) && !rd && gc_en_i;
        own_hit_o  = !rsvd && (addr7 == own_addr_i) && !rd;
        cmd_hw_o   = byte_i[0];
        cmd_rst_o  = (byte_i == CMD_RESET_LOAD);
        cmd_load_o = (byte_i == CMD_LOAD_ONLY);
    end
endmodule

// File: rtl/twi_gc_slave.sv
module twi_gc_slave #(
    parameter int         PROG_W      = 3,
    parameter logic [6:0] BASE_ADDR   = 7'h50,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              gc_en_i,
    input  logic [PROG_W-1:0] addr_pins_i,
    output logic              sda_oe_o,
    output logic [7:0]        rx_data_o,
    output logic              rx_valid_o,
    output logic              soft_rst_o,
    output logic              addr_load_o,
    output logic              hw_call_o,
    output logic [6:0]        hw_master_o
);
    import twi_gc_pkg::*;

    localparam int          BITS_PER_BYTE = 8;
    localparam logic [3:0]  CNT_ACK_SET   = 4'(BITS_PER_BYTE);
    localparam logic [3:0]  CNT_ACK_END   = 4'(BITS_PER_BYTE + 1);
    localparam logic [PROG_W-1:0] PROG_RST = BASE_ADDR[PROG_W-1:0];

    typedef struct packed {
        twi_state_e        st;
        logic [3:0]        cnt;
        logic [7:0]        shreg;
        logic              oe;
        logic [PROG_W-1:0] prog;
        logic [7:0]        rx_data;
        logic              rx_vld;
        logic              srst;
        logic              load;
        logic              hw_vld;
        logic [6:0]        hw_addr;
    } core_t;

    core_t q, d;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic own_hit, gc_hit, cmd_hw, cmd_rst, cmd_load;
    logic [6:0] own_addr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign own_addr = {BASE_ADDR[6:PROG_W], q.prog};

    twi_addr_class u_cls (
        .byte_i     (q.shreg),
        .own_addr_i (own_addr),
        .gc_en_i    (gc_en_i),
        .own_hit_o  (own_hit),
        .gc_hit_o   (gc_hit),
        .cmd_hw_o   (cmd_hw),
        .cmd_rst_o  (cmd_rst),
        .cmd_load_o (cmd_load)
    );

    always_comb begin
        d        = q;
        d.rx_vld = 1'b0;
        d.srst   = 1'b0;
        d.load   = 1'b0;
        d.hw_vld = 1'b0;
        if (stop_det) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise && q.cnt < CNT_ACK_SET) begin
                d.shreg = {q.shreg[6:0], sda_lvl};
                d.cnt   = q.cnt + 4'd1;
            end else if (scl_fall && q.cnt == CNT_ACK_SET) begin
                d.cnt = CNT_ACK_END;
                unique case (q.st)
                    ST_ADDR: begin
                        if (gc_hit) begin
                            d.oe = 1'b1;
                            d.st = ST_GCMD;
                        end else if (own_hit) begin
                            d.oe = 1'b1;
                            d.st = ST_DATA;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_GCMD: begin
                        if (cmd_hw) begin
                            d.oe      = 1'b1;
                            d.hw_addr = q.shreg[7:1];
                            d.hw_vld  = 1'b1;
                            d.st      = ST_DATA;
                        end else if (cmd_rst || cmd_load) begin
                            d.oe   = 1'b1;
                            d.load = 1'b1;
                            d.prog = addr_pins_i;
                            d.st   = ST_SKIP;
                            if (cmd_rst) begin
                                d.srst    = 1'b1;
                                d.hw_addr = '0;
                            end
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_DATA: begin
                        d.oe      = 1'b1;
                        d.rx_data = q.shreg;
                        d.rx_vld  = 1'b1;
                    end
                    default: d.oe = 1'b0;
                endcase
            end else if (scl_fall && q.cnt == CNT_ACK_END) begin
                d.cnt = '0;
                d.oe  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.prog    <= PROG_RST;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign rx_data_o   = q.rx_data;
    assign rx_valid_o  = q.rx_vld;
    assign soft_rst_o  = q.srst;
    assign addr_load_o = q.load;
    assign hw_call_o   = q.hw_vld;
    assign hw_master_o = q.hw_addr;

    // R3: data line is pulled only inside the acknowledge slot
    p_ack_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (q.cnt == CNT_ACK_END));

    // R2: every START brings the block back to address reception
    p_rearm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.cnt == 4'd0 && !sda_oe_o));

    // R5: a soft reset always comes with an address reload, for one cycle
    p_rst_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> addr_load_o);
    p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R6: programmable bits change only together with a load pulse
    p_prog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.prog) |-> addr_load_o);

    // R11: data strobes only while a transfer is accepted
    p_data_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (q.st == ST_DATA && sda_oe_o));
endmodule

// File: tb/sim_twi_gc_slave.sv
`timescale 1ns/1ps
module sim_twi_gc_slave;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       gc_en = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe, rx_valid, soft_rst, addr_load, hw_call;
    logic [7:0] rx_data;
    logic [6:0] hw_master;
    logic       sda_line;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    int         exp_kind[$];
    int         exp_val[$];
    string      exp_tag[$];

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twi_gc_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .gc_en_i     (gc_en),
        .addr_pins_i (pins),
        .sda_oe_o    (sda_oe),
        .rx_data_o   (rx_data),
        .rx_valid_o  (rx_valid),
        .soft_rst_o  (soft_rst),
        .addr_load_o (addr_load),
        .hw_call_o   (hw_call),
        .hw_master_o (hw_master)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kinds: 0 data, 1 hardware master, 2 soft reset, 3 address load
    task automatic expect_ev(input int kind, input int val, input string tag);
        exp_kind.push_back(kind);
        exp_val.push_back(val);
        exp_tag.push_back(tag);
    endtask

    task automatic seen_ev(input int kind, input int val);
        if (exp_kind.size() == 0) begin
            chk(1'b0, "unexpected output event", kind, -1);
        end else begin
            int    k = exp_kind.pop_front();
            int    v = exp_val.pop_front();
            string t = exp_tag.pop_front();
            chk(k == kind, t, kind, k);
            chk(v == val, t, val, v);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid)  seen_ev(0, int'(rx_data));
            if (hw_call)   seen_ev(1, int'(hw_master));
            if (soft_rst)  seen_ev(2, 0);
            if (addr_load) seen_ev(3, 0);
        end
    end

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tq();
        scl_m = 1'b1; tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tq();
        scl_m = 1'b1; tq();
        sda_m = 1'b1; tq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tq();
            scl_m = 1'b1; tq(); tq();
            scl_m = 1'b0; tq();
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic got;
        send_bits(b, 8);
        sda_m = 1'b1; tq();
        scl_m = 1'b1; tq();
        got = ~sda_line;
        tq();
        scl_m = 1'b0; tq();
        chk(got == exp_ack, tag, int'(got), int'(exp_ack));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && rx_valid == 1'b0 && soft_rst == 1'b0, "reset outputs R3", int'(sda_oe), 0);
        chk(hw_master == 7'd0, "reset hw address R8", int'(hw_master), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1, R11: write to own address 0x50, two data bytes
        bus_start();
        wr_byte(8'hA0, 1'b1, "own write address ack R1");
        expect_ev(0, 8'h3C, "data byte R11");
        wr_byte(8'h3C, 1'b1, "data ack R11");
        expect_ev(0, 8'hA5, "data byte R11");
        wr_byte(8'hA5, 1'b1, "data ack R11");
        chk(sda_oe == 1'b0, "released after ack R3", int'(sda_oe), 0);
        bus_stop();

        // R1, R13: address from pins not yet loaded, data after it ignored
        bus_start();
        wr_byte(8'hAA, 1'b0, "unloaded address nack R1");
        wr_byte(8'h12, 1'b0, "data after mismatch nack R13");
        bus_stop();

        // R1: read of own address refused
        bus_start();
        wr_byte(8'hA1, 1'b0, "own read nack R1");
        bus_stop();

        // R6: broadcast + 04h loads pins 101
        bus_start();
        wr_byte(8'h00, 1'b1, "broadcast ack R4");
        expect_ev(3, 0, "load pulse R6");
        wr_byte(8'h04, 1'b1, "load command ack R6");
        bus_stop();
        bus_start();
        wr_byte(8'hAA, 1'b1, "new address ack R6");
        expect_ev(0, 8'h5A, "data after reload R11");
        wr_byte(8'h5A, 1'b1, "data ack R11");
        bus_start();
        wr_byte(8'hA0, 1'b0, "old address nack R6");
        bus_stop();

        // R4: broadcast refused when disabled, following byte ignored
        gc_en = 1'b0;
        bus_start();
        wr_byte(8'h00, 1'b0, "broadcast disabled nack R4");
        wr_byte(8'h06, 1'b0, "command ignored R4");
        bus_stop();
        gc_en = 1'b1;

        // R9: START byte never acknowledged
        bus_start();
        wr_byte(8'h01, 1'b0, "start byte nack R9");
        bus_stop();

        // R10: reserved groups
        bus_start();
        wr_byte(8'hF8, 1'b0, "reserved 1111xxx nack R10");
        bus_start();
        wr_byte(8'h0A, 1'b0, "reserved 0000xxx nack R10");
        bus_stop();

        // R7: undefined even commands refused without pulses
        bus_start();
        wr_byte(8'h00, 1'b1, "broadcast ack R4");
        wr_byte(8'h00, 1'b0, "command 00h nack R7");
        bus_start();
        wr_byte(8'h00, 1'b1, "broadcast ack R4");
        wr_byte(8'h08, 1'b0, "command 08h nack R7");
        wr_byte(8'h33, 1'b0, "byte after bad command nack R7");
        bus_stop();

        // R8: hardware master 0x01 then data
        bus_start();
        wr_byte(8'h00, 1'b1, "broadcast ack R4");
        expect_ev(1, 7'h01, "hw master capture R8");
        wr_byte(8'h03, 1'b1, "hw call ack R8");
        expect_ev(0, 8'h77, "hw master data R8");
        wr_byte(8'h77, 1'b1, "hw data ack R8");
        bus_stop();
        chk(hw_master == 7'h01, "hw address held R8", int'(hw_master), 1);

        // R5: reset + load with pins 011
        pins = 3'b011;
        bus_start();
        wr_byte(8'h00, 1'b1, "broadcast ack R4");
        expect_ev(2, 0, "soft reset pulse R5");
        expect_ev(3, 0, "load with reset R5");
        wr_byte(8'h06, 1'b1, "reset command ack R5");
        bus_stop();
        chk(hw_master == 7'd0, "hw address cleared R5", int'(hw_master), 0);
        bus_start();
        wr_byte(8'hA6, 1'b1, "address 0x53 ack R5");
        bus_stop();

        // R2: repeated START inside a transfer and inside a byte
        bus_start();
        wr_byte(8'hA6, 1'b1, "address ack R2");
        expect_ev(0, 8'h11, "data before restart R2");
        wr_byte(8'h11, 1'b1, "data ack R2");
        send_bits(8'hFF, 4);
        bus_start();
        wr_byte(8'hA6, 1'b1, "address after mid-byte restart R2");
        expect_ev(0, 8'h22, "data after restart R2");
        wr_byte(8'h22, 1'b1, "data ack R2");
        bus_stop();

        // R12: START then STOP, then a normal transfer
        bus_start();
        bus_stop();
        tq(); tq();
        chk(exp_kind.size() == 0, "no event from void message R12", exp_kind.size(), 0);
        bus_start();
        wr_byte(8'hA6, 1'b1, "address after void message R12");
        expect_ev(0, 8'h81, "data after void message R12");
        wr_byte(8'h81, 1'b1, "data ack R12");
        bus_stop();

        tq(); tq();
        chk(exp_kind.size() == 0, "all expected events seen R11", exp_kind.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule